// File: doc/BRIEF.md
# Mask Candidate Enumerator

This block takes one received word of `W` bits and turns it into every member of a small coset: the word XORed with each of the `2^L` linear combinations, over GF(2), of `L` stored mask rows. It holds the rows in a register bank that is written one row at a time. For each accepted word it emits `2^L` candidates back to back on a valid/ready output. Each candidate carries an `L`-bit lane tag. The tag names the combination used, so a downstream demultiplexer can send the candidate to the decoder lane with that index.

The candidates follow a reflected Gray sequence. Step `s` carries lane `s ^ (s >> 1)`, so moving from one candidate to the next XORs in exactly one mask row. One `W`-bit register and one row multiplexer are all the datapath needs. The first candidate of every burst is the word itself, with lane 0. The block takes no new word until the final candidate of the current burst has been accepted downstream.

Top module: `mask_enum`

## Requirements
- R1: While `rstN` is low, and in the first cycle after it rises, `outValid` is low and `inReady` is high.
- R2: In a cycle with `maskWe` high, the row at index `maskSel` takes the value of `maskRow` at the clock edge. Words accepted after that edge use the new row value.
- R3: A word is accepted when `inValid` and `inReady` are both high at an edge. In the next cycle `outValid` is high, `outLane` is 0 and `outWord` equals the accepted word unmodified.
- R4: The step counter `s` starts at 0 for each word and advances by one on each output handshake. Step `s` carries `outLane` = `s XOR (s >> 1)`, so exactly `2^L` candidates are emitted per word.
- R5: `outWord` equals the accepted word XOR every mask row `i` for which bit `i` of `outLane` is 1.
- R6: Consecutive candidates of one burst have lane tags that differ in exactly one bit.
- R7: While `outValid` is high and `outReady` is low, `outWord`, `outLane` and `outLast` stay stable.
- R8: `outLast` is high exactly on the final candidate of a burst, the step with `outLane` = `1 << (L-1)`.
- R9: From an acceptance until the final candidate is accepted, `inReady` is low. `inValid` and `inWord` have no effect on the output during that time.
- R10: In the cycle after the final candidate is accepted, `outValid` is low and `inReady` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| maskWe | input | 1 | Mask row write strobe |
| maskSel | input | max(1, clog2(L)) | Index of the row being written |
| maskRow | input | W | Row value to write |
| inValid | input | 1 | Input word offered |
| inReady | output | 1 | Block can accept a word |
| inWord | input | W | Received word |
| outValid | output | 1 | Candidate offered |
| outReady | input | 1 | Downstream accepts the candidate |
| outWord | output | W | Demasked candidate |
| outLane | output | L | Combination index, which is also the destination lane |
| outLast | output | 1 | Final candidate of the burst |

## Verification
Assertions check four things on every cycle:
- an acceptance yields lane 0 carrying the unmodified word;
- lane tags step by a single bit;
- the output holds under backpressure;
- `outLast` lines up with the top lane, and the burst stays valid until that last candidate is taken.

Only the bench scenarios can show the rest. These cover the XOR content of every candidate against the stored rows, and the full count of `2^L` candidates per word. They also cover row rewrites between bursts, input words that change while the block is busy, and the one-cycle idle gap between bursts. The bench shows these under both random and continuous downstream readiness.

// File: rtl/mask_enum_pkg.sv
package mask_enum_pkg;
  // Row index width wide enough for the largest supported L (5 rows).
  localparam int ROW_IDX_W = 3;
  localparam int MAX_ROWS  = 5;

  typedef struct packed {
    logic                 capture;  // load the incoming word
    logic                 advance;  // XOR one mask row into the candidate
    logic [ROW_IDX_W-1:0] rowIdx;   // which row to XOR in
  } strobe_t;
endpackage

// File: rtl/mask_enum_ctrl.sv
module mask_enum_ctrl
  import mask_enum_pkg::*;
#(
  parameter int L = 3
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         inValid,
  output logic         inReady,
  output logic         outValid,
  input  logic         outReady,
  output logic [L-1:0] outLane,
  output logic         outLast,
  output strobe_t      strobe
);
  logic         busy;
  logic [L-1:0] step;
  logic [L-1:0] nextStep;
  logic         accept;
  logic         fire;
  logic         lastStep;

  assign nextStep = step + 1'b1;
  assign accept   = inValid && !busy;
  assign fire     = busy && outReady;
  assign lastStep = &step;

  assign inReady  = !busy;
  assign outValid = busy;
  assign outLane  = step ^ (step >> 1);
  assign outLast  = busy && lastStep;

  // Moving from gray(s) to gray(s+1) flips the bit at the lowest set bit of s+1.
  always_comb begin
    strobe.capture = accept;
    strobe.advance = fire && !lastStep;
    strobe.rowIdx  = '0;
    for (int i = L - 1; i >= 0; i--) begin
      if (nextStep[i]) strobe.rowIdx = ROW_IDX_W'(i);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy <= 1'b0;
      step <= '0;
    end else if (accept) begin
      busy <= 1'b1;
      step <= '0;
    end else if (fire) begin
      if (lastStep) busy <= 1'b0;
      else          step <= nextStep;
    end
  end

  // R3: an acceptance opens a burst at lane 0
  a_r3_first_lane: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady) |=> (outValid && outLane == '0));

  // R6: one row enters per step
  a_r6_single_flip: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outReady && !outLast) |=> ($countones(outLane ^ $past(outLane)) == 1));

  // R8: the final candidate carries the top lane
  a_r8_last_lane: assert property (@(posedge clk) disable iff (!rstN)
    outLast |-> (outLane == L'(1 << (L - 1))));

  // R9: a burst is never abandoned before its last candidate is taken
  a_r9_burst_holds: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !(outReady && outLast)) |=> (outValid && !inReady));

  // R10: the final handshake returns the block to idle
  a_r10_idle_after_last: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outReady && outLast) |=> (inReady && !outValid));
endmodule

// File: rtl/mask_enum_dp.sv
module mask_enum_dp
  import mask_enum_pkg::*;
#(
  parameter int W    = 16,
  parameter int L    = 3,
  parameter int IDXW = 2
) (
  input  logic            clk,
  input  logic            rstN,
  input  strobe_t         strobe,
  input  logic            maskWe,
  input  logic [IDXW-1:0] maskSel,
  input  logic [W-1:0]    maskRow,
  input  logic [W-1:0]    inWord,
  output logic [W-1:0]    outWord
);
  logic [W-1:0] rows [L];
  logic [W-1:0] rowPick;
  logic [W-1:0] curWord;

  for (genvar g = 0; g < L; g++) begin : g_row
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                  rows[g] <= '0;
      else if (maskWe && maskSel == IDXW'(g))     rows[g] <= maskRow;
    end
  end

  always_comb begin
    rowPick = '0;
    for (int i = 0; i < L; i++) begin
      if (strobe.rowIdx == ROW_IDX_W'(i)) rowPick = rows[i];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               curWord <= '0;
    else if (strobe.capture) curWord <= inWord;
    else if (strobe.advance) curWord <= curWord ^ rowPick;
  end

  assign outWord = curWord;

  // R3: the first candidate is the captured word untouched
  a_r3_unmodified: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capture |=> (outWord == $past(inWord)));
endmodule

// File: rtl/mask_enum.sv
module mask_enum
  import mask_enum_pkg::*;
#(
  parameter int W = 16,
  parameter int L = 3,
  localparam int IDXW = (L > 1) ? $clog2(L) : 1
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            maskWe,
  input  logic [IDXW-1:0] maskSel,
  input  logic [W-1:0]    maskRow,
  input  logic            inValid,
  output logic            inReady,
  input  logic [W-1:0]    inWord,
  output logic            outValid,
  input  logic            outReady,
  output logic [W-1:0]    outWord,
  output logic [L-1:0]    outLane,
  output logic            outLast
);
  strobe_t strobe;

  initial begin
    a_param_rows: assert (L >= 1 && L <= MAX_ROWS);
  end

  mask_enum_ctrl #(.L(L)) u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .outValid(outValid), .outReady(outReady), .outLane(outLane),
    .outLast(outLast), .strobe(strobe)
  );

  mask_enum_dp #(.W(W), .L(L), .IDXW(IDXW)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .maskWe(maskWe),
    .maskSel(maskSel), .maskRow(maskRow), .inWord(inWord), .outWord(outWord)
  );

  // R7: backpressure freezes the offered candidate
  a_r7_hold: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> ($stable(outWord) && $stable(outLane) && $stable(outLast)));
endmodule

// File: tb/mask_enum_bench.sv
module mask_enum_bench;
  localparam int  W      = 16;
  localparam int  L      = 3;
  localparam int  IDXW   = (L > 1) ? $clog2(L) : 1;
  localparam int  NCAND  = 1 << L;
  localparam time PERIOD = 10;
  localparam int  CYCLES = 820;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            maskWe = 1'b0;
  logic [IDXW-1:0] maskSel = '0;
  logic [W-1:0]    maskRow = '0;
  logic            inValid = 1'b0;
  logic            inReady;
  logic [W-1:0]    inWord = '0;
  logic            outValid;
  logic            outReady = 1'b0;
  logic [W-1:0]    outWord;
  logic [L-1:0]    outLane;
  logic            outLast;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // Behavioural model state
  logic [W-1:0] mRows [L];
  logic [W-1:0] mWord;
  int           mStep;
  bit           mBusy;
  int           wordsDone;

  mask_enum #(.W(W), .L(L)) u_mask_enum (
    .clk(clk), .rstN(rstN), .maskWe(maskWe), .maskSel(maskSel), .maskRow(maskRow),
    .inValid(inValid), .inReady(inReady), .inWord(inWord), .outValid(outValid),
    .outReady(outReady), .outWord(outWord), .outLane(outLane), .outLast(outLast)
  );

  always #(PERIOD / 2) clk = ~clk;

  function automatic logic [W-1:0] expWord(int step);
    logic [W-1:0] acc;
    int gray;
    gray = step ^ (step >> 1);
    acc = mWord;
    for (int i = 0; i < L; i++) if ((gray >> i) & 1) acc ^= mRows[i];
    return acc;
  endfunction

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  initial begin
    for (int i = 0; i < L; i++) mRows[i] = '0;
    mWord = '0; mStep = 0; mBusy = 0; wordsDone = 0;
    for (int c = 0; c < CYCLES; c++) begin
      @(negedge clk);
      // Compare outputs against the model state after the last edge
      if (!rstN) begin
        check(outValid == 1'b0, "R1 outValid in reset", 32'(outValid), 0);
        check(inReady == 1'b1, "R1 inReady in reset", 32'(inReady), 1);
      end else begin
        check(outValid == mBusy, "R3/R10 outValid", 32'(outValid), 32'(mBusy));
        check(inReady == !mBusy, "R9/R10 inReady", 32'(inReady), 32'(!mBusy));
        if (mBusy) begin
          check(outLane == L'(mStep ^ (mStep >> 1)), "R4 lane order",
                32'(outLane), 32'(mStep ^ (mStep >> 1)));
          check(outWord == expWord(mStep), "R5 candidate content",
                32'(outWord), 32'(expWord(mStep)));
          check(outLast == (mStep == NCAND - 1), "R8 last flag",
                32'(outLast), 32'(mStep == NCAND - 1));
        end
      end
      // Drive stimulus for the coming edge
      rstN   = (c >= 4);
      maskWe = 1'b0;
      inWord = W'($urandom);
      if (c >= 4 && c < 4 + L) begin
        // R2: initial row load while idle
        maskWe = 1'b1; maskSel = IDXW'(c - 4); maskRow = W'(16'h1111 * (c - 3) + 16'h0300);
        inValid = 1'b0; outReady = 1'b1;
      end else if (c < 300) begin
        inValid = 1'b1; outReady = ($urandom % 4) != 0;
      end else if (c < 320) begin
        inValid = 1'b0; outReady = 1'b1;
      end else if (c < 320 + L) begin
        // R2: rewrite rows between bursts
        maskWe = 1'b1; maskSel = IDXW'(c - 320); maskRow = W'($urandom);
        inValid = 1'b0; outReady = 1'b1;
      end else if (c < 600) begin
        inValid = 1'b1; outReady = 1'b1;
      end else begin
        inValid = ($urandom % 2) != 0; outReady = ($urandom % 3) != 0;
      end
      // Advance the model to what the coming edge produces
      if (!rstN) begin
        mBusy = 0; mStep = 0; mWord = '0;
        for (int i = 0; i < L; i++) mRows[i] = '0;
      end else begin
        if (mBusy && outReady) begin
          if (mStep == NCAND - 1) begin mBusy = 0; wordsDone++; end
          else mStep++;
        end else if (!mBusy && inValid) begin
          mBusy = 1; mStep = 0; mWord = inWord;
        end
        if (maskWe) mRows[maskSel] = maskRow;
      end
    end
    check(wordsDone > 40, "R4 bursts completed", 32'(wordsDone), 41);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(PERIOD * (CYCLES + 200));
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule